// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block runs the pins of an asynchronous NAND flash bus for one command descriptor at a time. A descriptor is presented together with a one-cycle `cmd_start` pulse. It carries five things: an operation (write bytes, read bytes, or wait for the ready/busy line), a target (command latch, address latch or plain data), a chip index, an auto-step flag, and a byte count. It also carries a flag that keeps the chip enable held once the descriptor completes. All strobe timing is given in clock cycles by three timing inputs, and the wait operation uses a fourth one. The block then drives CE#, CLE, ALE, WE#, RE# and the data bus.

In a write, bytes are taken from a valid/ready byte stream and placed on the bus. In a read, each byte is sampled as its read strobe ends and is handed out as a single-cycle valid pulse. A wait descriptor watches the ready/busy input and gives up after a programmable number of 4096-cycle units. Every descriptor ends with a one-cycle `done` pulse, and a wait that gives up raises `timeout` in that same cycle. The timing inputs must stay stable while a descriptor runs.

Top module: `nand_cycle_seq`

## Requirements
- R1: After a synchronous reset, every CE# is high, CLE and ALE are low, WE# and RE# are high, `nand_dq_oe`, `busy`, `done`, `timeout`, `in_ready` and `out_valid` are low.
- R2: In a write (mode 0), each byte keeps WE# low for max(`tm_data_setup`,1) cycles and then high for max(`tm_data_hold`,1) cycles. The byte stays on `nand_dq_out` with `nand_dq_oe` high through both phases. When the stream has data, the next byte's low phase starts in the following cycle, so one byte takes setup+hold cycles. A timing value of zero acts as one cycle.
- R3: Once a byte descriptor is accepted, CE#, CLE or ALE assert with both strobes high for max(`tm_addr_setup`,1) cycles before the first strobe falls.
- R4: Target 1 drives CLE and target 2 drives ALE during the transfer. Target 0 or 3 drives neither. With target 1 and `cmd_incr` set, the first byte goes out under CLE and every later byte goes out under ALE. Without `cmd_incr`, every byte uses CLE.
- R5: In a read (mode 1), each byte keeps RE# low for max(setup,1) cycles and then high for max(hold,1) cycles. `nand_dq_in` is sampled at the clock edge that ends the low phase. `out_valid` pulses for one cycle, in the first cycle RE# is high again, with that byte on `out_data`.
- R6: In a write, if the stream has no byte when one is needed, WE# stays high, CLE/ALE and CE# are held and `in_ready` stays high. The byte cycle starts in the cycle after the byte is accepted.
- R7: A wait descriptor (mode 2 or 3) asserts the selected CE# with no strobe, CLE or ALE and ignores the count. It ends when `nand_rb` is seen high, after at least one wait cycle.
- R8: If `nand_rb` stays low for max(`tm_busy_units`,1)×4096 wait cycles, the descriptor ends and `timeout` is high together with `done`.
- R9: `done` is a one-cycle pulse in the cycle after the last hold phase or wait cycle, and `busy` is low in that cycle. A read or write with a count of zero produces `done` in the cycle after `cmd_start`, with no strobe.
- R10: Only the selected chip's CE# is driven low. With `cmd_lock` set it stays low after `done`. Without `cmd_lock` it returns high in the `done` cycle. A new descriptor switches CE# to its own chip.
- R11: A `cmd_start` pulse while `busy` is high is ignored and does not change the descriptor in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | Accepts the descriptor fields when idle |
| cmd_mode | input | 2 | 0 write, 1 read, 2/3 wait for ready |
| cmd_target | input | 2 | 0 data, 1 command latch, 2 address latch, 3 data |
| cmd_cs | input | CS_W | Chip index |
| cmd_incr | input | 1 | Step from command latch to address latch after the first byte |
| cmd_lock | input | 1 | Hold chip enable after completion |
| cmd_count | input | CNT_W | Byte count |
| tm_addr_setup | input | 8 | Latch setup cycles before the first strobe |
| tm_data_setup | input | 8 | Strobe low cycles |
| tm_data_hold | input | 8 | Strobe high cycles |
| tm_busy_units | input | 16 | Wait limit in 4096-cycle units |
| in_data | input | 8 | Write stream byte |
| in_valid | input | 1 | Write stream byte present |
| in_ready | output | 1 | Write stream byte taken this cycle if valid |
| out_data | output | 8 | Read byte |
| out_valid | output | 1 | Read byte pulse |
| nand_ce_n | output | NCS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven in writes |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data received in reads |
| nand_rb | input | 1 | Ready (high) / busy (low) |
| busy | output | 1 | Descriptor in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Wait gave up, with done |

## Verification
A wrong phase counter or state shows up within one cycle as a strobe edge that comes early or late. That edge is seen in WE#, RE#, CLE/ALE or `in_ready`. A wrong byte counter or target step shows up at the end of the next byte as a wrong latch line or a missing or extra strobe. The remaining count and the wait counter are visible only through when `done` and `timeout` arrive, so they are compared in the exact completion cycle. Every port is therefore compared against a model on every clock, and the first deviation is reported in the cycle it appears.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int TIME_W  = 8;
    localparam int BT_W    = 16;
    localparam int UNIT_SH = 12;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_WAIT  = 2'd2
    } op_mode_e;

    typedef enum logic [1:0] {
        TG_DATA = 2'd0,
        TG_CMD  = 2'd1,
        TG_ADDR = 2'd2
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOAD  = 3'd2,
        ST_LOW   = 3'd3,
        ST_HIGH  = 3'd4,
        ST_WAIT  = 3'd5
    } st_e;

    function automatic logic [TIME_W-1:0] at_least_one(input logic [TIME_W-1:0] v);
        return (v == '0) ? TIME_W'(1) : v;
    endfunction

    function automatic op_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd0:    return OP_WRITE;
            2'd1:    return OP_READ;
            default: return OP_WAIT;
        endcase
    endfunction

    function automatic tgt_e decode_tgt(input logic [1:0] code);
        case (code)
            2'd1:    return TG_CMD;
            2'd2:    return TG_ADDR;
            default: return TG_DATA;
        endcase
    endfunction

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + W'(1);
    end

    assign last = (cnt == limit - W'(1));

endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
    parameter int UW = 16,
    parameter int SH = 12,
    localparam int CW = UW + SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          active,
    input  logic          rb,
    input  logic [UW-1:0] units,
    output logic          hit,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic [UW-1:0] units_eff;
    logic [CW-1:0] lim;

    assign units_eff = (units == '0) ? UW'(1) : units;
    assign lim       = {units_eff, {SH{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || arm)  cnt <= '0;
        else if (active) cnt <= cnt + CW'(1);
    end

    assign hit     = active && rb;
    assign expired = active && !rb && (cnt == lim - CW'(1));

    p_wait_below_limit_r8: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < lim));

endmodule

// File: rtl/nand_pin_map.sv
module nand_pin_map
    import nand_seq_pkg::*;
#(
    parameter int NCS = 4,
    localparam int CS_W = $clog2(NCS)
) (
    input  st_e             state,
    input  tgt_e            tgt,
    input  op_mode_e        mode,
    input  logic            ce_on,
    input  logic [CS_W-1:0] cs,
    output logic [NCS-1:0]  ce_n,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic            dq_oe
);
    logic xfer;
    logic strobe_phase;

    assign xfer = (state == ST_SETUP) || (state == ST_LOAD) ||
                  (state == ST_LOW)   || (state == ST_HIGH);
    assign strobe_phase = (state == ST_LOW);

    genvar i;
    generate
        for (i = 0; i < NCS; i++) begin : g_ce
            assign ce_n[i] = !(ce_on && (cs == CS_W'(i)));
        end
    endgenerate

    assign cle   = xfer && (tgt == TG_CMD);
    assign ale   = xfer && (tgt == TG_ADDR);
    assign we_n  = !(strobe_phase && (mode == OP_WRITE));
    assign re_n  = !(strobe_phase && (mode == OP_READ));
    assign dq_oe = (mode == OP_WRITE) && ((state == ST_LOW) || (state == ST_HIGH));

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int CNT_W = 16,
    localparam int CS_W = $clog2(NCS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_mode,
    input  logic [1:0]        cmd_target,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic              cmd_incr,
    input  logic              cmd_lock,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [TIME_W-1:0] tm_addr_setup,
    input  logic [TIME_W-1:0] tm_data_setup,
    input  logic [TIME_W-1:0] tm_data_hold,
    input  logic [BT_W-1:0]   tm_busy_units,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic [NCS-1:0]    nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [BYTE_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [BYTE_W-1:0] nand_dq_in,
    input  logic              nand_rb,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    st_e               state, state_n;
    op_mode_e          mode_r;
    tgt_e              tgt_r;
    logic              incr_r, lock_r, ce_on;
    logic [CS_W-1:0]   cs_r;
    logic [CNT_W-1:0]  remain;
    logic [BYTE_W-1:0] wbyte;

    logic              take_cmd, zero_start, finish, expire_now;
    logic              phase_last, rb_hit, rb_expired, accept, is_write, more_bytes;
    logic [TIME_W-1:0] phase_lim;

    assign take_cmd   = (state == ST_IDLE) && cmd_start;
    assign zero_start = take_cmd && (decode_mode(cmd_mode) != OP_WAIT) && (cmd_count == '0);
    assign is_write   = (mode_r == OP_WRITE);
    assign more_bytes = (remain != CNT_W'(1));

    always_comb begin
        case (state)
            ST_SETUP: phase_lim = at_least_one(tm_addr_setup);
            ST_LOW:   phase_lim = at_least_one(tm_data_setup);
            default:  phase_lim = at_least_one(tm_data_hold);
        endcase
    end

    nand_phase_timer #(.W(TIME_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (state_n != state),
        .limit   (phase_lim),
        .last    (phase_last)
    );

    nand_rb_watch #(.UW(BT_W), .SH(UNIT_SH)) u_rbw (
        .clk     (clk),
        .rst     (rst),
        .arm     (take_cmd),
        .active  (state == ST_WAIT),
        .rb      (nand_rb),
        .units   (tm_busy_units),
        .hit     (rb_hit),
        .expired (rb_expired)
    );

    always_comb begin
        in_ready = 1'b0;
        if (is_write) begin
            case (state)
                ST_SETUP: in_ready = phase_last;
                ST_LOAD:  in_ready = 1'b1;
                ST_HIGH:  in_ready = phase_last && more_bytes;
                default:  in_ready = 1'b0;
            endcase
        end
    end
    assign accept = in_ready && in_valid;

    always_comb begin
        state_n    = state;
        finish     = 1'b0;
        expire_now = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_start) begin
                    if (decode_mode(cmd_mode) == OP_WAIT) state_n = ST_WAIT;
                    else if (cmd_count != '0)             state_n = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (phase_last) state_n = (is_write && !in_valid) ? ST_LOAD : ST_LOW;
            end
            ST_LOAD: begin
                if (in_valid) state_n = ST_LOW;
            end
            ST_LOW: begin
                if (phase_last) state_n = ST_HIGH;
            end
            ST_HIGH: begin
                if (phase_last) begin
                    if (!more_bytes) begin
                        state_n = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_n = (is_write && !in_valid) ? ST_LOAD : ST_LOW;
                    end
                end
            end
            ST_WAIT: begin
                if (rb_hit || rb_expired) begin
                    state_n    = ST_IDLE;
                    finish     = 1'b1;
                    expire_now = !rb_hit;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode_r    <= OP_WRITE;
            tgt_r     <= TG_DATA;
            incr_r    <= 1'b0;
            lock_r    <= 1'b0;
            cs_r      <= '0;
            ce_on     <= 1'b0;
            remain    <= '0;
            wbyte     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            state     <= state_n;
            done      <= finish || zero_start;
            timeout   <= expire_now;
            out_valid <= 1'b0;
            if (take_cmd) begin
                mode_r <= decode_mode(cmd_mode);
                tgt_r  <= decode_tgt(cmd_target);
                incr_r <= cmd_incr;
                lock_r <= cmd_lock;
                cs_r   <= cmd_cs;
                remain <= cmd_count;
                ce_on  <= zero_start ? cmd_lock : 1'b1;
            end
            if (accept) wbyte <= in_data;
            if ((state == ST_LOW) && phase_last && (mode_r == OP_READ)) begin
                out_data  <= nand_dq_in;
                out_valid <= 1'b1;
            end
            if ((state == ST_HIGH) && phase_last && more_bytes) begin
                remain <= remain - CNT_W'(1);
                if ((tgt_r == TG_CMD) && incr_r) tgt_r <= TG_ADDR;
            end
            if (finish) ce_on <= lock_r;
        end
    end

    nand_pin_map #(.NCS(NCS)) u_pins (
        .state (state),
        .tgt   (tgt_r),
        .mode  (mode_r),
        .ce_on (ce_on),
        .cs    (cs_r),
        .ce_n  (nand_ce_n),
        .cle   (nand_cle),
        .ale   (nand_ale),
        .we_n  (nand_we_n),
        .re_n  (nand_re_n),
        .dq_oe (nand_dq_oe)
    );

    assign nand_dq_out = wbyte;
    assign busy        = (state != ST_IDLE);

    p_strobes_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));
    p_low_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n && !$past(nand_we_n)) |->
            ($stable(nand_dq_out) && $stable(nand_cle) && $stable(nand_ale)));
    p_cle_ale_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));
    p_valid_on_re_rise_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (nand_re_n && !$past(nand_re_n)));
    p_wait_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));
    p_tmo_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        timeout |-> done);
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_ce_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nand_ce_n));
    p_strobe_needs_ce_r10: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> ($countones(~nand_ce_n) == 1));

endmodule

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
    localparam int NCS = 4;

    typedef struct packed {
        logic [3:0] ce_n;
        logic       cle, ale, we_n, re_n, oe;
        logic [7:0] dq;
        logic       irdy, ovld;
        logic [7:0] od;
        logic       dn, tmo, bsy;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        cmd_start = 0;
    logic [1:0]  cmd_mode = 0, cmd_target = 0;
    logic [1:0]  cmd_cs = 0;
    logic        cmd_incr = 0, cmd_lock = 0;
    logic [15:0] cmd_count = 0;
    logic [7:0]  tm_addr_setup = 1, tm_data_setup = 1, tm_data_hold = 1;
    logic [15:0] tm_busy_units = 1;
    logic [7:0]  in_data = 0;
    logic        in_valid = 0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb = 1;
    logic        busy, done, timeout;

    nand_cycle_seq u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
        .cmd_target(cmd_target), .cmd_cs(cmd_cs), .cmd_incr(cmd_incr),
        .cmd_lock(cmd_lock), .cmd_count(cmd_count), .tm_addr_setup(tm_addr_setup),
        .tm_data_setup(tm_data_setup), .tm_data_hold(tm_data_hold),
        .tm_busy_units(tm_busy_units), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .busy(busy), .done(done), .timeout(timeout)
    );

    int     checks = 0, failures = 0, cyc = 0;
    string  cur_req = "R1";
    bit     chk_on = 0;
    bit     ce_on_m = 0;
    int     cs_m = 0;
    exp_t   exp_q[$];
    logic [7:0] feed_q[$];
    int     feed_hold = 0, rb_hold = 0;
    logic [7:0] rd_base = 0;
    int     rd_idx = 0;

    assign nand_dq_in = rd_base + 8'(rd_idx);
    always @(posedge nand_re_n) rd_idx++;

    function automatic exp_t idle_pins();
        exp_t e;
        e = '0;
        e.ce_n = ce_on_m ? ~(4'b0001 << cs_m) : 4'hF;
        e.we_n = 1; e.re_n = 1;
        return e;
    endfunction

    function automatic logic [7:0] wbyte(input logic [7:0] base, input int j);
        return base + 8'(j * 29);
    endfunction

    // stream feeder and ready/busy driver
    always @(posedge clk) begin
        if (in_valid && in_ready) void'(feed_q.pop_front());
        if (feed_hold > 0) feed_hold--;
        if (rb_hold > 0) rb_hold--;
        #1;
        in_valid = (feed_q.size() > 0) && (feed_hold == 0);
        in_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
        nand_rb  = (rb_hold == 0);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            exp_t e, a;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_pins();
            a = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe,
                 nand_dq_out, in_ready, out_valid, out_data, done, timeout, busy};
            if (!e.oe)   begin a.dq = 0; e.dq = 0; end
            if (!e.ovld) begin a.od = 0; e.od = 0; end
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, a, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Entered at posedge+1; builds the expected waveform and drives the descriptor.
    task automatic do_desc(input int mode, input int tgt, input int incr, input int lock,
                           input int cs, input int cnt, input int as_, input int ds,
                           input int dh, input int hold, input int bt,
                           input logic [7:0] base, input bit poke, input string req);
        exp_t act, e;
        int A, D, H, W, lim, L;
        bit wr;
        cur_req = req;
        A = (as_ < 1) ? 1 : as_;
        D = (ds < 1) ? 1 : ds;
        H = (dh < 1) ? 1 : dh;
        wr = (mode == 0);
        tm_addr_setup = 8'(as_); tm_data_setup = 8'(ds); tm_data_hold = 8'(dh);
        tm_busy_units = 16'(bt);
        cmd_mode = 2'(mode); cmd_target = 2'(tgt); cmd_incr = incr[0];
        cmd_lock = lock[0]; cmd_cs = 2'(cs); cmd_count = 16'(cnt);
        cmd_start = 1;
        exp_q.push_back(idle_pins());
        if (mode >= 2) begin
            rb_hold = hold;
            W = (hold < 1) ? 1 : hold;
            lim = ((bt < 1) ? 1 : bt) * 4096;
            ce_on_m = 1; cs_m = cs;
            act = idle_pins(); act.bsy = 1;
            for (int k = 0; k < ((W > lim) ? lim : W); k++) exp_q.push_back(act);
            ce_on_m = lock[0];
            e = idle_pins(); e.dn = 1; e.tmo = (W > lim);
            exp_q.push_back(e);
        end else if (cnt == 0) begin
            ce_on_m = lock[0]; cs_m = cs;
            e = idle_pins(); e.dn = 1;
            exp_q.push_back(e);
        end else begin
            ce_on_m = 1; cs_m = cs;
            act = idle_pins(); act.bsy = 1;
            if (wr) begin
                for (int j = 0; j < cnt; j++) feed_q.push_back(wbyte(base, j));
                feed_hold = hold;
            end else begin
                rd_base = base; rd_idx = 0;
            end
            L = (wr && hold > A) ? hold - A : 0;
            for (int k = 0; k < A; k++) begin
                e = act; e.cle = (tgt == 1); e.ale = (tgt == 2);
                e.irdy = wr && (k == A - 1);
                exp_q.push_back(e);
            end
            for (int k = 0; k < L; k++) begin
                e = act; e.cle = (tgt == 1); e.ale = (tgt == 2); e.irdy = 1;
                exp_q.push_back(e);
            end
            for (int j = 0; j < cnt; j++) begin
                bit c, a;
                c = (tgt == 1) && !(incr != 0 && j > 0);
                a = (tgt == 2) || (tgt == 1 && incr != 0 && j > 0);
                for (int k = 0; k < D; k++) begin
                    e = act; e.cle = c; e.ale = a; e.oe = wr; e.dq = wbyte(base, j);
                    if (wr) e.we_n = 0; else e.re_n = 0;
                    exp_q.push_back(e);
                end
                for (int k = 0; k < H; k++) begin
                    e = act; e.cle = c; e.ale = a; e.oe = wr; e.dq = wbyte(base, j);
                    e.irdy = wr && (k == H - 1) && (j < cnt - 1);
                    e.ovld = !wr && (k == 0); e.od = base + 8'(j);
                    exp_q.push_back(e);
                end
            end
            ce_on_m = lock[0];
            e = idle_pins(); e.dn = 1;
            exp_q.push_back(e);
        end
        @(posedge clk); #1;
        cmd_start = 0;
        if (poke) begin
            repeat (2) @(posedge clk);
            #1;
            cmd_start = 1; cmd_mode = 2'd2; cmd_cs = 2'd3; cmd_count = 16'd0;
            @(posedge clk); #1;
            cmd_start = 0;
        end
        while (exp_q.size() > 0) @(posedge clk);
        #1;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        chk_on = 1;
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1;
        // R2 R3: plain data write, distinct setup and hold
        do_desc(0, 0, 0, 0, 1, 3, 2, 2, 3, 0, 1, 8'h11, 0, "R2");
        // R2: zero timing fields act as one cycle
        do_desc(0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 1, 8'h40, 0, "R2");
        // R3: long latch setup before first strobe
        do_desc(0, 2, 0, 0, 2, 1, 5, 1, 1, 0, 1, 8'h7E, 0, "R3");
        // R4: command latch stepping to address latch
        do_desc(0, 1, 1, 0, 0, 4, 1, 2, 1, 0, 1, 8'hC3, 0, "R4");
        do_desc(0, 1, 0, 0, 0, 2, 1, 1, 2, 0, 1, 8'h05, 0, "R4");
        do_desc(0, 3, 1, 0, 3, 2, 1, 1, 1, 0, 1, 8'h90, 0, "R4");
        // R5: reads, with the address-step as well
        do_desc(1, 0, 0, 0, 1, 3, 2, 3, 1, 0, 1, 8'h20, 0, "R5");
        do_desc(1, 1, 1, 0, 2, 3, 1, 1, 2, 0, 1, 8'hE0, 0, "R5");
        // R6: stream empty at first byte
        do_desc(0, 0, 0, 0, 0, 2, 2, 1, 1, 6, 1, 8'h33, 0, "R6");
        // R7: wait with count ignored, and immediate ready
        do_desc(2, 1, 0, 0, 3, 7, 1, 1, 1, 5, 1, 8'h00, 0, "R7");
        do_desc(3, 0, 0, 0, 1, 0, 1, 1, 1, 0, 1, 8'h00, 0, "R7");
        // R8: timeout with one unit, and with zero units
        do_desc(2, 0, 0, 0, 2, 0, 1, 1, 1, 1 << 30, 1, 8'h00, 0, "R8");
        do_desc(2, 0, 0, 0, 0, 0, 1, 1, 1, 1 << 30, 0, 8'h00, 0, "R8");
        rb_hold = 0;
        repeat (2) @(posedge clk);
        #1;
        // R9: zero count write and read
        do_desc(0, 1, 0, 0, 1, 0, 3, 3, 3, 0, 1, 8'h00, 0, "R9");
        do_desc(1, 0, 0, 1, 2, 0, 3, 3, 3, 0, 1, 8'h00, 0, "R9");
        // R10: locked chip enable then switch to another chip
        do_desc(0, 0, 0, 1, 2, 1, 1, 1, 1, 0, 1, 8'hAA, 0, "R10");
        do_desc(2, 0, 0, 1, 3, 0, 1, 1, 1, 2, 1, 8'h00, 0, "R10");
        do_desc(1, 0, 0, 0, 1, 1, 1, 2, 1, 0, 1, 8'h60, 0, "R10");
        // R11: start pulse during a running descriptor
        do_desc(0, 1, 1, 0, 0, 3, 2, 2, 2, 0, 1, 8'h5C, 1, "R11");
        repeat (4) @(posedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule